// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register window between a host bus and an embedded keyboard-controller core. Bytes pass both ways through two single-byte buffers. The output byte carries data from the controller to the host. The input byte carries data or commands from the host to the controller. A status byte shows the full and empty state of both buffers, a command/data marker and controller-owned flags.

The host reaches the block through a synchronous address/strobe port. The data offset (60h) and the command offset (64h) both load the same input byte. The block records which offset was used, so the controller can tell a command from data. Host reads of 60h return the output byte and clear its full flag. Host reads of 64h return the status byte. Read data is registered and appears one cycle after the strobe.

The controller side has strobes to load the output byte, to take the input byte, to clear or toggle a general-purpose flag and to load four spare flags. Each side can be notified by an enabled interrupt level or can poll the status byte.

Top module: `kbd_mailbox`

## Requirements
- R1: After reset, kc_status is 00h, host_rdata is 00h, and host_irq and kc_ibf_irq are 0.
- R2: A host write to offset 60h or 64h loads host_wdata into the input byte, which is visible on kc_ibuf_data after that clock edge. A host write to any other address changes no state.
- R3: Status bit 0 (output full) is set by kc_obuf_wr, which also replaces the output byte, and is cleared by a host read of 60h. If both occur in the same cycle the bit stays set: the read returns the old byte and the new byte is kept.
- R4: Status bit 1 (input full) is set by a mapped host write and cleared by kc_ibuf_rd. If both occur in the same cycle the bit stays set. A write while the bit is set replaces the byte.
- R5: Status bit 3 is 1 after a mapped host write to 64h (command) and 0 after one to 60h (data).
- R6: Status bit 2 is inverted by kc_f0_tgl and cleared by kc_f0_clr. When both are asserted together, the clear wins.
- R7: Status bits 7 to 4 are loaded from kc_gp_data when kc_gp_wr is high and hold otherwise.
- R8: host_rdata is updated one cycle after a host_rd strobe. A read of 60h returns the output byte. A read of 64h returns the status byte {bits 7:4 flags, bit 3, bit 2, input full, output full} as it stood before that cycle's updates. A read of any other address returns 00h. Between reads, host_rdata holds its value.
- R9: In each cycle, host_irq equals output-full AND the value host_irq_en had in the previous cycle. kc_ibf_irq is formed the same way from input-full and kc_ibf_irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host address |
| host_wr | input | 1 | Host single-cycle write strobe |
| host_rd | input | 1 | Host single-cycle read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| host_irq_en | input | 1 | Enable for the host interrupt |
| host_irq | output | 1 | Host interrupt request, output byte ready |
| kc_obuf_wr | input | 1 | Controller loads the output byte |
| kc_obuf_data | input | 8 | Byte for the output buffer |
| kc_ibuf_rd | input | 1 | Controller takes the input byte |
| kc_ibuf_data | output | 8 | Current input byte |
| kc_status | output | 8 | Status byte as seen by the controller |
| kc_f0_clr | input | 1 | Clear status bit 2 |
| kc_f0_tgl | input | 1 | Invert status bit 2 |
| kc_gp_wr | input | 1 | Load status bits 7:4 |
| kc_gp_data | input | 4 | Value for status bits 7:4 |
| kc_ibf_irq_en | input | 1 | Enable for the controller interrupt |
| kc_ibf_irq | output | 1 | Controller interrupt, input byte arrived |

## Verification
A wrong full flag shows up at once on kc_status and on the interrupt levels, one edge after the access that should have moved it. The same edge lets a later host read of 64h return it. A wrong byte or a lost command/data marker appears on kc_ibuf_data one edge after the host write, or on host_rdata one edge after the read that fetches it. The sweeps therefore compare every byte value and every address at the first cycle where each result can be seen. The same-cycle collisions are forced on purpose, because a wrong priority there shows as a lost byte only in that single cycle.

// File: rtl/kbd_mailbox_pkg.sv
package kbd_mailbox_pkg;
  // Status byte positions; host software and controller firmware both decode these.
  localparam int unsigned ST_OBF  = 0;
  localparam int unsigned ST_IBF  = 1;
  localparam int unsigned ST_F0   = 2;
  localparam int unsigned ST_CMD  = 3;
  localparam int unsigned ST_GP_LO = 4;
endpackage

// File: rtl/kbm_flag_cell.sv
// One full/empty flag written from two sides; a set beats a clear.
module kbm_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  always_comb begin
    nxt_o = q_o;
    if (clr_i) nxt_o = 1'b0;
    if (set_i) nxt_o = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/kbm_byte_reg.sv
// Loadable data holding register.
module kbm_byte_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/kbm_host_port.sv
// Host address decode and registered read mux.
module kbm_host_port #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DATA_OFS = 'h60,
  parameter int unsigned CMD_OFS  = 'h64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] obuf_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              wr_hit_o,
  output logic              wr_cmd_o,
  output logic              rd_data_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);

  logic at_data, at_cmd;
  assign at_data   = (addr_i == A_DATA);
  assign at_cmd    = (addr_i == A_CMD);
  assign wr_hit_o  = wr_i && (at_data || at_cmd);
  assign wr_cmd_o  = wr_i && at_cmd;
  assign rd_data_o = rd_i && at_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (at_data)     rdata_o <= obuf_i;
      else if (at_cmd) rdata_o <= status_i;
      else             rdata_o <= '0;
    end
  end
endmodule

// File: rtl/kbd_mailbox.sv
module kbd_mailbox
  import kbd_mailbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DATA_OFS = 'h60,
  parameter int unsigned CMD_OFS  = 'h64,
  localparam int unsigned GP_W    = DATA_W - ST_GP_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              host_irq_en,
  output logic              host_irq,
  input  logic              kc_obuf_wr,
  input  logic [DATA_W-1:0] kc_obuf_data,
  input  logic              kc_ibuf_rd,
  output logic [DATA_W-1:0] kc_ibuf_data,
  output logic [DATA_W-1:0] kc_status,
  input  logic              kc_f0_clr,
  input  logic              kc_f0_tgl,
  input  logic              kc_gp_wr,
  input  logic [GP_W-1:0]   kc_gp_data,
  input  logic              kc_ibf_irq_en,
  output logic              kc_ibf_irq
);
  logic wr_hit, wr_cmd, rd_data;
  logic obf_q, obf_nxt, ibf_q, ibf_nxt;
  logic f0_q, cmd_q;
  logic [GP_W-1:0]   gp_q;
  logic [DATA_W-1:0] obuf_q;

  assign kc_status = {gp_q, cmd_q, f0_q, ibf_q, obf_q};

  kbm_host_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)
  ) u_port (
    .clk(clk), .rst(rst), .addr_i(host_addr), .wr_i(host_wr), .rd_i(host_rd),
    .obuf_i(obuf_q), .status_i(kc_status),
    .wr_hit_o(wr_hit), .wr_cmd_o(wr_cmd), .rd_data_o(rd_data), .rdata_o(host_rdata)
  );

  kbm_flag_cell u_obf (
    .clk(clk), .rst(rst), .set_i(kc_obuf_wr), .clr_i(rd_data),
    .nxt_o(obf_nxt), .q_o(obf_q)
  );

  kbm_flag_cell u_ibf (
    .clk(clk), .rst(rst), .set_i(wr_hit), .clr_i(kc_ibuf_rd),
    .nxt_o(ibf_nxt), .q_o(ibf_q)
  );

  kbm_byte_reg #(.W(DATA_W)) u_obuf (
    .clk(clk), .rst(rst), .load_i(kc_obuf_wr), .d_i(kc_obuf_data), .q_o(obuf_q)
  );

  kbm_byte_reg #(.W(DATA_W)) u_ibuf (
    .clk(clk), .rst(rst), .load_i(wr_hit), .d_i(host_wdata), .q_o(kc_ibuf_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= 1'b0;
      f0_q       <= 1'b0;
      gp_q       <= '0;
      host_irq   <= 1'b0;
      kc_ibf_irq <= 1'b0;
    end else begin
      if (wr_hit)         cmd_q <= wr_cmd;
      if (kc_f0_clr)      f0_q  <= 1'b0;
      else if (kc_f0_tgl) f0_q  <= ~f0_q;
      if (kc_gp_wr)       gp_q  <= kc_gp_data;
      host_irq   <= host_irq_en & obf_nxt;
      kc_ibf_irq <= kc_ibf_irq_en & ibf_nxt;
    end
  end
endmodule

// File: rtl/kbm_checker.sv
module kbm_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DATA_OFS = 'h60,
  parameter int unsigned CMD_OFS  = 'h64
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_wdata,
  input logic              kc_obuf_wr,
  input logic              kc_f0_clr,
  input logic              kc_f0_tgl,
  input logic [DATA_W-1:0] kc_ibuf_data,
  input logic [DATA_W-1:0] kc_status,
  input logic              host_irq,
  input logic              kc_ibf_irq
);
  logic hit_d, hit_c;
  assign hit_d = host_addr == ADDR_W'(DATA_OFS);
  assign hit_c = host_addr == ADDR_W'(CMD_OFS);

  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (kc_status == '0) && !host_irq && !kc_ibf_irq); // R1
  AST_IBUF_LOAD: assert property (@(posedge clk) disable iff (rst)
    host_wr && (hit_d || hit_c) |=> kc_ibuf_data == $past(host_wdata)); // R2
  AST_OBF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    kc_obuf_wr |=> kc_status[0]); // R3
  AST_OBF_DRAIN: assert property (@(posedge clk) disable iff (rst)
    host_rd && hit_d && !kc_obuf_wr |=> !kc_status[0]); // R3
  AST_IBF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    host_wr && (hit_d || hit_c) |=> kc_status[1]); // R4
  AST_CMD_MARK: assert property (@(posedge clk) disable iff (rst)
    host_wr && (hit_d || hit_c) |=> kc_status[3] == $past(hit_c)); // R5
  AST_F0_FLIP: assert property (@(posedge clk) disable iff (rst)
    kc_f0_tgl && !kc_f0_clr |=> kc_status[2] != $past(kc_status[2])); // R6
  AST_F0_CLEAR: assert property (@(posedge clk) disable iff (rst)
    kc_f0_clr |=> !kc_status[2]); // R6
  AST_HOST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> kc_status[0]); // R9
  AST_KC_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    kc_ibf_irq |-> kc_status[1]); // R9
endmodule

bind kbd_mailbox kbm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)
) u_kbm_checker (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .kc_obuf_wr(kc_obuf_wr), .kc_f0_clr(kc_f0_clr),
  .kc_f0_tgl(kc_f0_tgl), .kc_ibuf_data(kc_ibuf_data), .kc_status(kc_status),
  .host_irq(host_irq), .kc_ibf_irq(kc_ibf_irq)
);

// File: tb/tb_kbd_mailbox.sv
`timescale 1ns/1ps
module tb_kbd_mailbox;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] host_addr = '0, host_wdata = '0, kc_obuf_data = '0;
  logic       host_wr = 0, host_rd = 0, host_irq_en = 1, kc_obuf_wr = 0, kc_ibuf_rd = 0;
  logic       kc_f0_clr = 0, kc_f0_tgl = 0, kc_gp_wr = 0, kc_ibf_irq_en = 1;
  logic [3:0] kc_gp_data = '0;
  logic [7:0] host_rdata, kc_ibuf_data, kc_status;
  logic       host_irq, kc_ibf_irq;

  int checks = 0, errors = 0;
  logic done = 0;
  // bench model of controller-owned flags
  logic [3:0] m_gp = '0;
  logic       m_f0 = 0, m_cmd = 0;

  always #4 clk = ~clk;

  kbd_mailbox dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq_en(host_irq_en),
    .host_irq(host_irq), .kc_obuf_wr(kc_obuf_wr), .kc_obuf_data(kc_obuf_data),
    .kc_ibuf_rd(kc_ibuf_rd), .kc_ibuf_data(kc_ibuf_data), .kc_status(kc_status),
    .kc_f0_clr(kc_f0_clr), .kc_f0_tgl(kc_f0_tgl), .kc_gp_wr(kc_gp_wr),
    .kc_gp_data(kc_gp_data), .kc_ibf_irq_en(kc_ibf_irq_en), .kc_ibf_irq(kc_ibf_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    host_wr = 0; host_rd = 0; kc_obuf_wr = 0; kc_ibuf_rd = 0;
    kc_f0_clr = 0; kc_f0_tgl = 0; kc_gp_wr = 0;
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1; step();
  endtask

  task automatic hread(input logic [7:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1; step(); d = host_rdata;
  endtask

  function automatic logic [7:0] mstat(input logic ibf, input logic obf);
    return {m_gp, m_cmd, m_f0, ibf, obf};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, zval;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 status", kc_status, 8'h00);
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 irqs", {host_irq, kc_ibf_irq}, 2'b00);

    // input path: every byte, alternating data/command offsets
    for (int d = 0; d < 256; d++) begin
      hwrite(d[0] ? 8'h64 : 8'h60, d[7:0]);
      m_cmd = d[0];
      chk("R2 ibuf", kc_ibuf_data, d[7:0]);
      chk("R4 ibf set", kc_status[1], 1'b1);
      chk("R5 cmd flag", kc_status[3], d[0]);
      chk("R9 kc irq", kc_ibf_irq, 1'b1);
      kc_ibuf_rd = 1; step();
      chk("R4 ibf clr", kc_status[1], 1'b0);
      chk("R9 kc irq off", kc_ibf_irq, 1'b0);
    end

    // output path: every byte, status read on some
    for (int d = 0; d < 256; d++) begin
      kc_obuf_data = d[7:0]; kc_obuf_wr = 1; step();
      chk("R3 obf set", kc_status[0], 1'b1);
      chk("R9 host irq", host_irq, 1'b1);
      if (d % 16 == 3) begin
        hread(8'h64, rd);
        chk("R8 status read", rd, mstat(1'b0, 1'b1));
      end
      hread(8'h60, rd);
      chk("R8 obuf read", rd, d[7:0]);
      chk("R3 obf clr", kc_status[0], 1'b0);
      chk("R9 host irq off", host_irq, 1'b0);
    end

    // collision: controller write meets host read of 60h
    kc_obuf_data = 8'hA5; kc_obuf_wr = 1; step();
    kc_obuf_data = 8'h3C; kc_obuf_wr = 1; host_addr = 8'h60; host_rd = 1; step();
    chk("R3 old byte on read", host_rdata, 8'hA5);
    chk("R3 obf kept", kc_status[0], 1'b1);
    hread(8'h60, rd);
    chk("R3 new byte kept", rd, 8'h3C);
    // overwrite of the output byte while full
    kc_obuf_data = 8'h11; kc_obuf_wr = 1; step();
    kc_obuf_data = 8'h22; kc_obuf_wr = 1; step();
    hread(8'h60, rd);
    chk("R3 overwrite", rd, 8'h22);

    // collision: host write meets controller take
    hwrite(8'h60, 8'h5A); m_cmd = 0;
    host_addr = 8'h64; host_wdata = 8'hC3; host_wr = 1; kc_ibuf_rd = 1; step(); m_cmd = 1;
    chk("R4 ibf kept", kc_status[1], 1'b1);
    chk("R2 ibuf collide", kc_ibuf_data, 8'hC3);
    hwrite(8'h60, 8'h77); m_cmd = 0;
    chk("R4 overwrite", kc_ibuf_data, 8'h77);
    chk("R5 overwrite flag", kc_status[3], 1'b0);
    kc_ibuf_rd = 1; step();

    // F0 toggle/clear
    kc_f0_tgl = 1; step(); chk("R6 tgl1", kc_status[2], 1'b1);
    kc_f0_tgl = 1; step(); chk("R6 tgl0", kc_status[2], 1'b0);
    kc_f0_tgl = 1; step(); chk("R6 tgl1b", kc_status[2], 1'b1);
    kc_f0_tgl = 1; kc_f0_clr = 1; step(); chk("R6 clr wins", kc_status[2], 1'b0);
    kc_f0_clr = 1; step(); chk("R6 clr idle", kc_status[2], 1'b0);
    kc_f0_tgl = 1; step(); m_f0 = 1;

    // general flags sweep
    for (int g = 0; g < 16; g++) begin
      kc_gp_data = g[3:0]; kc_gp_wr = 1; step(); m_gp = g[3:0];
      kc_gp_data = ~g[3:0]; step();
      chk("R7 gp hold", kc_status[7:4], g[3:0]);
      hread(8'h64, rd);
      chk("R8 status gp", rd, mstat(1'b0, 1'b0));
    end

    // unmapped addresses: no effect, read returns zero
    zval = 8'h96;
    hwrite(8'h60, zval); m_cmd = 0;
    kc_ibuf_rd = 1; step();
    kc_obuf_data = 8'hE1; kc_obuf_wr = 1; step();
    for (int a = 0; a < 256; a++) begin
      if (a == 'h60 || a == 'h64) continue;
      hwrite(a[7:0], ~a[7:0]);
      hread(a[7:0], rd);
      chk("R8 unmapped read", rd, 8'h00);
      chk("R2 unmapped write", {kc_ibuf_data, kc_status}, {zval, mstat(1'b0, 1'b1)});
    end
    hread(8'h60, rd);
    chk("R8 obuf after sweep", rd, 8'hE1);
    step(); step();
    chk("R8 rdata holds", host_rdata, 8'hE1);

    // interrupt enables
    host_irq_en = 0; kc_obuf_data = 8'h01; kc_obuf_wr = 1; step();
    chk("R9 host irq masked", {host_irq, kc_status[0]}, 2'b01);
    host_irq_en = 1; step();
    chk("R9 host irq unmasked", host_irq, 1'b1);
    kc_ibf_irq_en = 0; hwrite(8'h60, 8'h02);
    chk("R9 kc irq masked", {kc_ibf_irq, kc_status[1]}, 2'b01);
    kc_ibf_irq_en = 1; step();
    chk("R9 kc irq unmasked", kc_ibf_irq, 1'b1);

    rst = 1; step(); rst = 0;
    chk("R1 reset again", {kc_status, host_rdata, host_irq, kc_ibf_irq}, 18'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule